// File: doc/BRIEF.md
# On-chip ROM bus slave

This block is a read-only memory that answers a 16-bit internal bus. It holds 4096 words of 16 bits (8 KB). The contents are fixed when the design is elaborated: a seed and a multiplier, both parameters, define each word, so no external file is needed. A master presents an address, a transfer size, an address-space code and a read/write strobe, and holds the strobe until the block acknowledges. Byte and aligned word reads need one bus cycle. Misaligned words, long words and misaligned long words are served as a fixed run of back-to-back 16-bit bus cycles. The bytes are then assembled and returned right-justified on a 32-bit read bus.

Two small configuration registers sit in their own address window. They set where the 8 KB array appears, how many extra clocks every bus cycle takes, which address spaces may reach the array, and whether reset-vector fetches near address zero are answered from the array. A sticky lock bit freezes all of this until the next reset.

Top module: `rom_slave`

## Requirements
- R1: After reset the control register (word at REG_BASE) reads lock in bit 15, boot enable in bit 14, supervisor-only in bit 5, program-only in bit 4 and the wait count in bits 2:0, all taken from their reset parameters. All other bits read 0. The base register (word at REG_BASE+2) reads the array base, address bits 23:13, in bits 10:0. After reset `bus_ack` is low and `bus_rdata` is zero.
- R2: A byte read returns a byte in `bus_rdata[7:0]`, with the upper bits zero. Array word i holds ((i*MULT) xor SEED) mod 2^16. The bytes are big-endian: an even address gives the upper byte of its word and an odd address gives the lower byte.
- R3: A word read (size code 1) at any address returns the two bytes at addr and addr+1, with addr's byte in bits 15:8 and the upper bits zero.
- R4: A long read (size code 2) at any address returns the four bytes addr..addr+3, with the first byte in bits 31:24.
- R5: An array access takes N bus cycles of (2+W) clocks each, where W is the wait count. N is 1 for a byte, 1 for an even word, 2 for an odd word, 2 for an even long and 3 for an odd long. `bus_ack` is seen N*(2+W) rising edges after the strobe is first driven, counting the edge that samples it.
- R6: A write to the wait field changes the latency of later array accesses. A register access always completes in 2 clocks, whatever the wait count.
- R7: With supervisor-only set, an array access whose space code has bit 1 clear gets no acknowledge. With program-only set, an access whose space code has bit 0 clear gets no acknowledge.
- R8: While boot enable is set, reads at byte addresses 0 to 7 are served from the same offsets of the array in any space, even when the array base is elsewhere. While it is clear, those addresses get no acknowledge.
- R9: Once the lock bit is written to 1 it stays 1 until reset. A register write while locked is acknowledged and changes nothing.
- R10: A write into the array region is acknowledged and leaves the array contents unchanged.
- R11: An address outside the array window, the register window and the enabled boot window never gets an acknowledge. The array window moves when the base register is written.
- R12: `bus_ack` is high for exactly one clock per access, and `bus_rdata` keeps its value between acknowledges.
- R13: A multi-byte read that runs past the last array byte wraps to offset 0 of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Transfer strobe, held by the master until acknowledged |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 24 | Byte address |
| bus_size | input | 2 | 0 byte, 1 word, 2 long |
| bus_space | input | 2 | Space code: bit 1 supervisor, bit 0 program |
| bus_wdata | input | 16 | Write data for the registers |
| bus_rdata | output | 32 | Right-justified read data |
| bus_ack | output | 1 | One-clock transfer acknowledge |

## Verification
A single register write can set the lock bit and change the wait count at the same time. The block must apply both at that one clock edge: the new wait count has to take effect even though the lock closes every later write. The bench provokes this with one control write carrying lock=1 and wait=2. It judges the result by reading the control register back, by checking that the next array read takes 4 clocks per bus cycle, and by checking that a later acknowledged write leaves both the wait count and the base unchanged.

// File: rtl/rom_slave_pkg.sv
package rom_slave_pkg;

    localparam int ADDR_W   = 24;
    localparam int BYTE_AW  = 13;
    localparam int WORD_AW  = BYTE_AW - 1;
    localparam int BASE_W   = ADDR_W - BYTE_AW;
    localparam int WAIT_W   = 3;
    localparam int PHASE_W  = WAIT_W + 1;
    localparam int ACC_W    = 40;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } xfer_size_e;

    typedef struct packed {
        logic              lock;
        logic              boot;
        logic              sup_only;
        logic              prog_only;
        logic [WAIT_W-1:0] wait_n;
    } cfg_t;

    typedef struct packed {
        logic               we;
        logic               is_reg;
        logic               reg_idx;
        xfer_size_e         size;
        logic               odd;
        logic [WORD_AW-1:0] widx;
    } req_t;

    function automatic logic [15:0] rom_word(input logic [WORD_AW-1:0] idx,
                                             input logic [15:0] seed,
                                             input logic [15:0] mult);
        logic [15:0] prod;
        prod = 16'(idx) * mult;
        return prod ^ seed;
    endfunction

    function automatic logic [1:0] beat_count(input xfer_size_e sz, input logic odd);
        case (sz)
            SZ_BYTE: return 2'd1;
            SZ_WORD: return odd ? 2'd2 : 2'd1;
            default: return odd ? 2'd3 : 2'd2;
        endcase
    endfunction

    function automatic logic [31:0] pick_bytes(input logic [ACC_W-1:0] acc,
                                               input xfer_size_e sz,
                                               input logic odd);
        logic [31:0] v;
        logic        sh;
        sh = (sz == SZ_BYTE) ? ~odd : odd;
        v  = 32'(acc >> (sh ? 8 : 0));
        case (sz)
            SZ_BYTE: return {24'd0, v[7:0]};
            SZ_WORD: return {16'd0, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/rom_cfg_regs.sv
module rom_cfg_regs
    import rom_slave_pkg::*;
#(
    parameter logic [BASE_W-1:0] BASE_RST  = 11'h001,
    parameter logic [WAIT_W-1:0] WAIT_RST  = '0,
    parameter logic [1:0]        SPACE_RST = 2'b00,
    parameter logic              BOOT_RST  = 1'b1,
    parameter logic              LOCK_RST  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_idx,
    input  logic [15:0]       wr_data,
    input  logic              rd_idx,
    output logic [15:0]       rd_data,
    output cfg_t              cfg_o,
    output logic [BASE_W-1:0] base_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o.lock      <= LOCK_RST;
            cfg_o.boot      <= BOOT_RST;
            cfg_o.sup_only  <= SPACE_RST[1];
            cfg_o.prog_only <= SPACE_RST[0];
            cfg_o.wait_n    <= WAIT_RST;
            base_o          <= BASE_RST;
        end else if (wr_en && !cfg_o.lock) begin
            if (!wr_idx) begin
                cfg_o.lock      <= wr_data[15];
                cfg_o.boot      <= wr_data[14];
                cfg_o.sup_only  <= wr_data[5];
                cfg_o.prog_only <= wr_data[4];
                cfg_o.wait_n    <= wr_data[WAIT_W-1:0];
            end else begin
                base_o <= wr_data[BASE_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_idx) begin
            rd_data[15]         = cfg_o.lock;
            rd_data[14]         = cfg_o.boot;
            rd_data[5]          = cfg_o.sup_only;
            rd_data[4]          = cfg_o.prog_only;
            rd_data[WAIT_W-1:0] = cfg_o.wait_n;
        end else begin
            rd_data[BASE_W-1:0] = base_o;
        end
    end

    // R9: lock, once set, holds until reset
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_o.lock |=> cfg_o.lock);

    // R9: a write while locked leaves every field unchanged
    p_locked_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_o.lock && wr_en) |=> ($stable(cfg_o) && $stable(base_o)));

endmodule

// File: rtl/rom_decode.sv
module rom_decode
    import rom_slave_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFF000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        space,
    input  logic              boot_en,
    input  logic              sup_only,
    input  logic              prog_only,
    input  logic [BASE_W-1:0] base,
    output logic              hit_reg,
    output logic              hit_arr,
    output logic              hit_boot
);

    logic space_ok;

    always_comb begin
        space_ok = (!sup_only || space[1]) && (!prog_only || space[0]);
        hit_reg  = (addr[ADDR_W-1:2] == REG_BASE[ADDR_W-1:2]);
        hit_arr  = !hit_reg && space_ok && (addr[ADDR_W-1:BYTE_AW] == base);
        hit_boot = !hit_reg && boot_en && (addr[ADDR_W-1:3] == '0);
    end

endmodule

// File: rtl/rom_access_seq.sv
module rom_access_seq
    import rom_slave_pkg::*;
#(
    parameter logic [15:0] SEED = 16'hA5C3,
    parameter logic [15:0] MULT = 16'h9E37
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              hit,
    input  req_t              req_in,
    input  logic [15:0]       wdata_in,
    input  logic [WAIT_W-1:0] wait_n,
    input  logic [15:0]       reg_rdata,
    output logic              reg_rd_idx,
    output logic              reg_wr_fire,
    output logic [15:0]       reg_wr_data,
    output logic              ack,
    output logic [31:0]       rdata
);

    req_t               r;
    logic               busy;
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] per_beat;
    logic [1:0]         beat;
    logic [1:0]         nbeats;
    logic [ACC_W-1:0]   acc;
    logic [ACC_W-1:0]   acc_next;
    logic [15:0]        word_now;
    logic               accept;
    logic               last_phase;
    logic               last_beat;

    always_comb begin
        accept     = stb && hit && !busy && !ack;
        last_phase = busy && (phase == per_beat - PHASE_W'(1));
        last_beat  = last_phase && (beat == nbeats - 2'd1);
        word_now   = rom_word(r.widx + WORD_AW'(beat), SEED, MULT);
        acc_next   = {acc[ACC_W-17:0], word_now};
    end

    assign reg_rd_idx  = r.reg_idx;
    assign reg_wr_fire = last_beat && r.is_reg && r.we;

    always_ff @(posedge clk) begin
        if (rst) begin
            r           <= '0;
            busy        <= 1'b0;
            phase       <= '0;
            per_beat    <= PHASE_W'(2);
            beat        <= '0;
            nbeats      <= 2'd1;
            acc         <= '0;
            ack         <= 1'b0;
            rdata       <= '0;
            reg_wr_data <= '0;
        end else begin
            ack <= 1'b0;
            if (accept) begin
                busy        <= 1'b1;
                r           <= req_in;
                phase       <= PHASE_W'(1);
                beat        <= '0;
                acc         <= '0;
                reg_wr_data <= wdata_in;
                nbeats      <= req_in.is_reg ? 2'd1 : beat_count(req_in.size, req_in.odd);
                per_beat    <= req_in.is_reg ? PHASE_W'(2) : PHASE_W'(2) + PHASE_W'(wait_n);
            end else if (busy) begin
                if (last_phase) begin
                    acc   <= acc_next;
                    phase <= '0;
                    beat  <= beat + 2'd1;
                    if (last_beat) begin
                        busy <= 1'b0;
                        ack  <= 1'b1;
                        if (r.is_reg)
                            rdata <= {16'd0, reg_rdata};
                        else if (r.we)
                            rdata <= '0;
                        else
                            rdata <= pick_bytes(acc_next, r.size, r.odd);
                    end
                end else begin
                    phase <= phase + PHASE_W'(1);
                end
            end
        end
    end

    // R12: acknowledge lasts one clock
    p_ack_single_r12: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R12: read data moves only together with an acknowledge
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ack || $stable(rdata)));

    // R5: no acknowledge without an access in flight
    p_ack_needs_busy_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !ack);

    // R5: beat index stays below the beat count of the access
    p_beat_bound_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (beat < nbeats));

endmodule

// File: rtl/rom_slave.sv
module rom_slave
    import rom_slave_pkg::*;
#(
    parameter logic [BASE_W-1:0] BASE_RST  = 11'h001,
    parameter logic [WAIT_W-1:0] WAIT_RST  = '0,
    parameter logic [1:0]        SPACE_RST = 2'b00,
    parameter logic              BOOT_RST  = 1'b1,
    parameter logic              LOCK_RST  = 1'b0,
    parameter logic [ADDR_W-1:0] REG_BASE  = 24'hFFF000,
    parameter logic [15:0]       SEED      = 16'hA5C3,
    parameter logic [15:0]       MULT      = 16'h9E37
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_stb,
    input  logic        bus_we,
    input  logic [23:0] bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [1:0]  bus_space,
    input  logic [15:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ack
);

    cfg_t              cfg;
    logic [BASE_W-1:0] base;
    logic              hit_reg, hit_arr, hit_boot;
    req_t              req_in;
    logic              reg_rd_idx, reg_wr_fire;
    logic [15:0]       reg_wr_data, reg_rdata;

    rom_decode #(.REG_BASE(REG_BASE)) decode_i (
        .addr      (bus_addr),
        .space     (bus_space),
        .boot_en   (cfg.boot),
        .sup_only  (cfg.sup_only),
        .prog_only (cfg.prog_only),
        .base      (base),
        .hit_reg   (hit_reg),
        .hit_arr   (hit_arr),
        .hit_boot  (hit_boot)
    );

    always_comb begin
        req_in.we      = bus_we;
        req_in.is_reg  = hit_reg;
        req_in.reg_idx = bus_addr[1];
        req_in.size    = xfer_size_e'(bus_size);
        req_in.odd     = bus_addr[0];
        req_in.widx    = bus_addr[BYTE_AW-1:1];
    end

    rom_cfg_regs #(
        .BASE_RST (BASE_RST),
        .WAIT_RST (WAIT_RST),
        .SPACE_RST(SPACE_RST),
        .BOOT_RST (BOOT_RST),
        .LOCK_RST (LOCK_RST)
    ) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_fire),
        .wr_idx  (reg_rd_idx),
        .wr_data (reg_wr_data),
        .rd_idx  (reg_rd_idx),
        .rd_data (reg_rdata),
        .cfg_o   (cfg),
        .base_o  (base)
    );

    rom_access_seq #(.SEED(SEED), .MULT(MULT)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .stb         (bus_stb),
        .hit         (hit_reg || hit_arr || hit_boot),
        .req_in      (req_in),
        .wdata_in    (bus_wdata),
        .wait_n      (cfg.wait_n),
        .reg_rdata   (reg_rdata),
        .reg_rd_idx  (reg_rd_idx),
        .reg_wr_fire (reg_wr_fire),
        .reg_wr_data (reg_wr_data),
        .ack         (bus_ack),
        .rdata       (bus_rdata)
    );

endmodule

// File: tb/rom_slave_tb_top.sv
module rom_slave_tb_top;

    localparam logic [15:0] SEED  = 16'hA5C3;
    localparam logic [15:0] MULT  = 16'h9E37;
    localparam int          BASE0 = 24'h002000;
    localparam int          REGA  = 24'hFFF000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [1:0]  bus_space = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rom_slave dut_i (
        .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_space(bus_space),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    function automatic logic [7:0] exp_byte(int o);
        int oo = o & 8191;
        int w  = (((oo >> 1) * MULT) ^ SEED) & 16'hFFFF;
        return (oo % 2 == 0) ? w[15:8] : w[7:0];
    endfunction

    function automatic logic [31:0] exp_data(int o, int sz);
        int len = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        logic [31:0] v = '0;
        for (int k = 0; k < len; k++) v = (v << 8) | 32'(exp_byte(o + k));
        return v;
    endfunction

    function automatic int exp_beats(int sz, int odd);
        if (sz == 0) return 1;
        if (sz == 1) return 1 + odd;
        return 2 + odd;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input int a, input int sz, input logic [1:0] sp, input bit we,
                        input logic [15:0] wd, output bit acked,
                        output logic [31:0] d, output int lat);
        @(negedge clk);
        bus_addr = 24'(a); bus_size = 2'(sz); bus_space = sp;
        bus_we = we; bus_wdata = wd; bus_stb = 1'b1;
        acked = 1'b0; d = '0; lat = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (bus_ack) begin
                acked = 1'b1;
                d = bus_rdata;
                break;
            end
        end
        bus_stb = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int sz, input logic [1:0] sp,
                          input int waitn, input int off);
        bit ak; logic [31:0] d; int lat;
        xfer(a, sz, sp, 1'b0, 16'h0, ak, d, lat);
        chk({req, " ack"}, 32'(ak), 32'd1);
        chk(req, d, exp_data(off, sz));
        chk("R5 latency", 32'(lat), 32'(exp_beats(sz, off & 1) * (2 + waitn)));
    endtask

    task automatic no_ack(input string req, input int a, input int sz,
                          input logic [1:0] sp, input bit we);
        bit ak; logic [31:0] d; int lat;
        xfer(a, sz, sp, we, 16'h0, ak, d, lat);
        chk(req, 32'(ak), 32'd0);
    endtask

    task automatic wr_reg(input int a, input logic [15:0] v);
        bit ak; logic [31:0] d; int lat;
        xfer(a, 1, 2'b00, 1'b1, v, ak, d, lat);
        chk("R9 reg write ack", 32'(ak), 32'd1);
    endtask

    task automatic rd_reg(input string req, input int a, input logic [15:0] v);
        bit ak; logic [31:0] d; int lat;
        xfer(a, 1, 2'b00, 1'b0, 16'h0, ak, d, lat);
        chk(req, d, {16'd0, v});
        chk("R6 reg latency", 32'(lat), 32'd2);
    endtask

    initial begin
        bit ak; logic [31:0] d, held; int lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 ack after reset", 32'(bus_ack), 32'd0);
        chk("R1 rdata after reset", bus_rdata, 32'd0);
        rd_reg("R1 ctrl default", REGA, 16'h4000);
        rd_reg("R1 base default", REGA + 2, 16'h0001);

        // R2 R3 R4 R5: sweep of sizes and offsets, wait 0
        for (int o = 0; o < 48; o++) begin
            rd_chk("R2 byte", BASE0 + o, 0, 2'b11, 0, o);
            rd_chk("R3 word", BASE0 + o, 1, 2'b11, 0, o);
            rd_chk("R4 long", BASE0 + o, 2, 2'b11, 0, o);
        end

        // R12: pulse is one clock, data held
        xfer(BASE0 + 5, 2, 2'b11, 1'b0, 16'h0, ak, held, lat);
        @(negedge clk);
        chk("R12 ack one clock", 32'(bus_ack), 32'd0);
        chk("R12 rdata held", bus_rdata, held);

        // R13: wrap past the end of the array
        rd_chk("R13 long wrap", BASE0 + 8190, 2, 2'b11, 0, 8190);
        rd_chk("R13 word wrap", BASE0 + 8191, 1, 2'b11, 0, 8191);
        rd_chk("R13 odd long wrap", BASE0 + 8189, 2, 2'b11, 0, 8189);

        // R6: wait count 3
        wr_reg(REGA, 16'h4003);
        rd_reg("R6 ctrl readback", REGA, 16'h4003);
        for (int o = 100; o < 104; o++) begin
            rd_chk("R6 byte wait", BASE0 + o, 0, 2'b11, 3, o);
            rd_chk("R6 word wait", BASE0 + o, 1, 2'b11, 3, o);
            rd_chk("R6 long wait", BASE0 + o, 2, 2'b11, 3, o);
        end

        // R7: space qualifier
        wr_reg(REGA, 16'h4020);
        no_ack("R7 user blocked", BASE0 + 4, 1, 2'b01, 1'b0);
        rd_chk("R7 supervisor ok", BASE0 + 4, 1, 2'b10, 0, 4);
        wr_reg(REGA, 16'h4010);
        no_ack("R7 data blocked", BASE0 + 4, 1, 2'b10, 1'b0);
        rd_chk("R7 program ok", BASE0 + 4, 1, 2'b01, 0, 4);
        wr_reg(REGA, 16'h4000);

        // R8: boot window
        rd_chk("R8 boot long 0", 0, 2, 2'b00, 0, 0);
        rd_chk("R8 boot long 4", 4, 2, 2'b10, 0, 4);
        rd_chk("R8 boot byte 7", 7, 0, 2'b00, 0, 7);
        no_ack("R8 outside window", 8, 1, 2'b00, 1'b0);
        wr_reg(REGA, 16'h0000);
        no_ack("R8 boot disabled", 0, 2, 2'b00, 1'b0);

        // R11: unmapped addresses
        no_ack("R11 unmapped", 24'h100000, 1, 2'b11, 1'b0);
        no_ack("R11 past regs", REGA + 4, 1, 2'b11, 1'b0);

        // R10: write to array ignored
        xfer(BASE0 + 10, 1, 2'b11, 1'b1, 16'hFFFF, ak, d, lat);
        chk("R10 array write ack", 32'(ak), 32'd1);
        rd_chk("R10 array unchanged", BASE0 + 10, 1, 2'b11, 0, 10);

        // R11: relocate base
        wr_reg(REGA + 2, 16'h0005);
        rd_reg("R11 base readback", REGA + 2, 16'h0005);
        rd_chk("R11 new base", 24'h00A000 + 6, 2, 2'b11, 0, 6);
        no_ack("R11 old base", BASE0 + 6, 2, 2'b11, 1'b0);

        // R9: lock and wait=2 land together
        wr_reg(REGA, 16'h8002);
        rd_reg("R9 lock set", REGA, 16'h8002);
        rd_chk("R9 wait applied", 24'h00A000 + 3, 2, 2'b11, 2, 3);
        wr_reg(REGA, 16'h0000);
        rd_reg("R9 ctrl frozen", REGA, 16'h8002);
        wr_reg(REGA + 2, 16'h0007);
        rd_reg("R9 base frozen", REGA + 2, 16'h0005);
        rd_chk("R9 wait still 2", 24'h00A000 + 1, 1, 2'b11, 2, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule